// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. The selector picks one entry from a small descriptor table held inside the block. Each entry stores a base, a limit and three permission bits. The linear address is the entry's base plus the offset. It is produced only when the offset stays within the entry's limit and the entry allows the requested kind of access. Otherwise the block returns a fault code and a zero address.

A host loads descriptors through a simple write port, one entry per clock. Translation requests arrive on a valid/ready handshake, at up to one per cycle. Each accepted request produces a registered response on the following cycle. The response side also uses valid/ready, so a consumer can stall the block.

Top module: `seg_xlate`

## Requirements
- R1: A request accepted in one cycle (req_valid and req_ready high at a rising edge) gives rsp_valid high in the next cycle.
- R2: With no fault, rsp_lin equals the entry base plus the offset, taken modulo 2^32.
- R3: A selector with any bit set at or above bit 3 (value 8 or more) gives fault code 1. This check wins over every other check.
- R4: An offset greater than the entry limit gives fault code 2; an offset equal to the limit passes. The limit check wins over the permission check.
- R5: Permission bit 0 allows read (access code 0), bit 1 allows write (code 1) and bit 2 allows fetch (code 2). A missing bit, or access code 3, gives fault code 3.
- R6: Whenever rsp_fault is nonzero, rsp_lin is zero.
- R7: req_ready is high exactly when rsp_valid is low or rsp_ready is high. While rsp_valid is high and rsp_ready is low, the response stays unchanged.
- R8: With wr_en high, entry wr_idx takes the new base, limit and permission at the clock edge. A request accepted in that same cycle uses the old contents, and later requests use the new ones.
- R9: After reset, rsp_valid, rsp_lin and rsp_fault are zero and every entry has base 0, limit 0 and no permissions. A read of selector 0 at offset 0 therefore faults with code 3.
- R10: rsp_valid returns low after a response is taken when no new request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 32 | New base |
| wr_limit | input | 32 | New limit (inclusive) |
| wr_perm | input | 3 | New permissions: bit0 read, bit1 write, bit2 fetch |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_sel | input | 16 | Selector |
| req_ofs | input | 32 | Offset |
| req_acc | input | 2 | Access: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_lin | output | 32 | Linear address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 bad selector, 2 limit, 3 permission |

## Verification
Two things can happen in the same cycle: a descriptor write and a translation through that same entry. The bench raises wr_en for entry 2 with a new base while a request for selector 2 is being accepted. It then expects the response to carry the old base, and a second request to carry the new one. A separate case overlaps a stalled response with a waiting request. In that case the bench expects the held response to stay fixed, and the queued request to be taken in the same edge that releases the held one.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_SEL   = 2'd1,
      FLT_LIMIT = 2'd2,
      FLT_PERM  = 2'd3
   } seg_fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } seg_acc_e;

   localparam int PERM_W   = 3;
   localparam int PERM_RD  = 0;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 2;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
   parameter int NUM_ENT = 8,
   parameter int ADDR_W  = 32,
   parameter int PERM_W  = 3,
   localparam int IDX_W  = $clog2(NUM_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_base,
   output logic [ADDR_W-1:0] rd_limit,
   output logic [PERM_W-1:0] rd_perm
);

   logic [ADDR_W-1:0] base_q  [NUM_ENT];
   logic [ADDR_W-1:0] limit_q [NUM_ENT];
   logic [PERM_W-1:0] perm_q  [NUM_ENT];

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[e]  <= '0;
            limit_q[e] <= '0;
            perm_q[e]  <= '0;
         end else if (hit) begin
            base_q[e]  <= wr_base;
            limit_q[e] <= wr_limit;
            perm_q[e]  <= wr_perm;
         end
      end
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_perm  = perm_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W   = 16,
   parameter int ADDR_W  = 32,
   parameter int NUM_ENT = 8,
   localparam int IDX_W  = $clog2(NUM_ENT)
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] ofs,
   input  logic [1:0]        acc,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   input  logic [PERM_W-1:0] perm,
   output logic [ADDR_W-1:0] lin,
   output logic [1:0]        fault
);

   logic sel_ok;
   logic perm_ok;

   if (IDX_W < SEL_W) begin : g_sel_range
      assign sel_ok = (sel[SEL_W-1:IDX_W] == '0);
   end else begin : g_sel_full
      assign sel_ok = 1'b1;
   end

   always_comb begin
      unique case (seg_acc_e'(acc))
         ACC_READ:  perm_ok = perm[PERM_RD];
         ACC_WRITE: perm_ok = perm[PERM_WR];
         ACC_FETCH: perm_ok = perm[PERM_EX];
         default:   perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!sel_ok)          fault = FLT_SEL;
      else if (ofs > limit) fault = FLT_LIMIT;
      else if (!perm_ok)    fault = FLT_PERM;
      else                  fault = FLT_NONE;
   end

   assign lin = (fault == FLT_NONE) ? (base + ofs) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W   = 16,
   parameter int ADDR_W  = 32,
   parameter int NUM_ENT = 8,
   localparam int IDX_W  = $clog2(NUM_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic [2:0]        wr_perm,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [ADDR_W-1:0] req_ofs,
   input  logic [1:0]        req_acc,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_lin,
   output logic [1:0]        rsp_fault
);

   if (NUM_ENT < 2 || (NUM_ENT & (NUM_ENT - 1)) != 0) begin : g_bad_ent
      $error("seg_xlate: NUM_ENT must be a power of two, at least 2");
   end
   if (IDX_W > SEL_W) begin : g_bad_sel
      $error("seg_xlate: table larger than selector range");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("seg_xlate: ADDR_W too small");
   end

   logic [ADDR_W-1:0] ent_base;
   logic [ADDR_W-1:0] ent_limit;
   logic [PERM_W-1:0] ent_perm;
   logic [ADDR_W-1:0] chk_lin;
   logic [1:0]        chk_fault;
   logic              take;

   seg_desc_table #(
      .NUM_ENT (NUM_ENT),
      .ADDR_W  (ADDR_W),
      .PERM_W  (PERM_W)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_base  (wr_base),
      .wr_limit (wr_limit),
      .wr_perm  (wr_perm),
      .rd_idx   (req_sel[IDX_W-1:0]),
      .rd_base  (ent_base),
      .rd_limit (ent_limit),
      .rd_perm  (ent_perm)
   );

   seg_check #(
      .SEL_W   (SEL_W),
      .ADDR_W  (ADDR_W),
      .NUM_ENT (NUM_ENT)
   ) i_check (
      .sel   (req_sel),
      .ofs   (req_ofs),
      .acc   (req_acc),
      .base  (ent_base),
      .limit (ent_limit),
      .perm  (ent_perm),
      .lin   (chk_lin),
      .fault (chk_fault)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_lin   <= '0;
         rsp_fault <= FLT_NONE;
      end else if (req_ready) begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_lin   <= chk_lin;
            rsp_fault <= chk_fault;
         end
      end
   end

   // R1: accepted request is answered next cycle
   a_r1_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> rsp_valid);

   // R6: faulting response carries zero address
   a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> rsp_lin == '0);

   // R7: stalled response is held
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lin) && $stable(rsp_fault)));

   // R3: out-of-table selector faults with code 1
   a_r3_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (req_sel >= SEL_W'(NUM_ENT))) |=> rsp_fault == FLT_SEL);

   // R4: in-table selector past the limit faults with code 2
   a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (req_sel < SEL_W'(NUM_ENT)) && (req_ofs > ent_limit)) |=> rsp_fault == FLT_LIMIT);

   // R10: idle after the response drains
   a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && rsp_ready) |=> !rsp_valid);

endmodule

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_base = '0;
   logic [31:0] wr_limit = '0;
   logic [2:0]  wr_perm = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_sel = '0;
   logic [31:0] req_ofs = '0;
   logic [1:0]  req_acc = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_lin;
   logic [1:0]  rsp_fault;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] mb [8];
   logic [31:0] ml [8];
   logic [2:0]  mp [8];

   always #2 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
      .wr_limit(wr_limit), .wr_perm(wr_perm),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_sel(req_sel), .req_ofs(req_ofs), .req_acc(req_acc),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_lin(rsp_lin), .rsp_fault(rsp_fault)
   );

   task automatic chk(input logic ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [33:0] model(input logic [15:0] sel, input logic [31:0] ofs, input logic [1:0] acc);
      logic [2:0] e;
      if (sel >= 16'd8) return {2'd1, 32'd0};
      e = sel[2:0];
      if (ofs > ml[e]) return {2'd2, 32'd0};
      if (acc == 2'd3 || !mp[e][acc]) return {2'd3, 32'd0};
      return {2'd0, mb[e] + ofs};
   endfunction

   task automatic load(input int e, input logic [31:0] b, input logic [31:0] l, input logic [2:0] p);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'(e); wr_base = b; wr_limit = l; wr_perm = p;
      @(negedge clk);
      wr_en = 1'b0;
      mb[e] = b; ml[e] = l; mp[e] = p;
   endtask

   task automatic xl(input logic [15:0] sel, input logic [31:0] ofs, input logic [1:0] acc, input string tag);
      logic [33:0] exp;
      exp = model(sel, ofs, acc);
      @(negedge clk);
      req_sel = sel; req_ofs = ofs; req_acc = acc; req_valid = 1'b1; rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid, {tag, " R1 valid"}, {33'd0, rsp_valid}, 34'd1);
      chk({rsp_fault, rsp_lin} == exp, tag, {rsp_fault, rsp_lin}, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [33:0] ea;
      logic [33:0] eb;
      for (int i = 0; i < 8; i++) begin mb[i] = '0; ml[i] = '0; mp[i] = '0; end
      repeat (3) @(negedge clk);
      chk(!rsp_valid && rsp_lin == 0 && rsp_fault == 0, "R9 reset outputs",
          {rsp_fault, rsp_lin}, 34'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R7 ready after reset", {33'd0, req_ready}, 34'd1);
      xl(16'd0, 32'd0, 2'd0, "R9 empty table");

      // table: perm = index (all combinations), varying base and limit
      for (int i = 0; i < 7; i++)
         load(i, 32'h1000_0000 * i + 32'h123 * i, 32'h0000_0FFF << i, 3'(i));
      load(7, 32'hFFFF_F000, 32'hFFFF_FFFF, 3'd7);

      // sweep: every entry, every access code, offsets around the limit
      for (int i = 0; i < 8; i++)
         for (int a = 0; a < 4; a++) begin
            xl(16'(i), 32'd0, 2'(a), "R5 sweep zero ofs");
            xl(16'(i), ml[i], 2'(a), "R4 sweep at limit");
            xl(16'(i), ml[i] + 32'd1, 2'(a), "R4 sweep past limit");
            xl(16'(i), 32'hFFFF_FFFF, 2'(a), "R4 sweep max ofs");
         end

      // wrap of base + offset
      xl(16'd7, 32'h0000_2345, 2'd2, "R2 wrap");
      chk(rsp_lin == 32'h0000_1345, "R2 wrap value", {2'd0, rsp_lin}, {2'd0, 32'h0000_1345});

      // bad selectors, including high bits with a valid low index
      xl(16'd8, 32'd0, 2'd0, "R3 sel 8");
      xl(16'h0103, 32'd0, 2'd0, "R3 high bits");
      xl(16'hFFFF, 32'hFFFF_FFFF, 2'd3, "R3 priority");
      xl(16'h8007, 32'd4, 2'd0, "R3 top bit");

      // same-cycle write and translate through entry 2
      ea = {2'd0, mb[2] + 32'd16};
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd2; wr_base = 32'hABCD_0000; wr_limit = ml[2]; wr_perm = mp[2];
      req_sel = 16'd2; req_ofs = 32'd16; req_acc = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      mb[2] = 32'hABCD_0000;
      chk({rsp_fault, rsp_lin} == ea, "R8 old contents", {rsp_fault, rsp_lin}, ea);
      xl(16'd2, 32'd16, 2'd1, "R8 new contents");

      // back-pressure
      ea = model(16'd3, 32'd5, 2'd0);
      eb = model(16'd1, 32'd7, 2'd0);
      @(negedge clk);
      req_sel = 16'd3; req_ofs = 32'd5; req_acc = 2'd0; req_valid = 1'b1; rsp_ready = 1'b0;
      @(negedge clk);
      chk(rsp_valid && {rsp_fault, rsp_lin} == ea, "R1 first under stall", {rsp_fault, rsp_lin}, ea);
      req_sel = 16'd1; req_ofs = 32'd7;
      chk(!req_ready, "R7 ready low", {33'd0, req_ready}, 34'd0);
      @(negedge clk);
      chk(rsp_valid && {rsp_fault, rsp_lin} == ea, "R7 held", {rsp_fault, rsp_lin}, ea);
      chk(!req_ready, "R7 still low", {33'd0, req_ready}, 34'd0);
      rsp_ready = 1'b1;
      #0.5;
      chk(req_ready, "R7 ready follows rsp_ready", {33'd0, req_ready}, 34'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && {rsp_fault, rsp_lin} == eb, "R7 queued taken", {rsp_fault, rsp_lin}, eb);
      @(negedge clk);
      chk(!rsp_valid, "R10 drain", {33'd0, rsp_valid}, 34'd0);

      // fault zeroes address even with large base
      xl(16'd7, 32'd0, 2'd3, "R6 reserved access");
      chk(rsp_lin == 32'd0, "R6 zero address", {2'd0, rsp_lin}, 34'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule